// File: doc/BRIEF.md
# Clock Source Select Register Bank

This block stores the source-select codes for a large set of clock multiplexers and presents each code on a select output. Selections are grouped four to a 32-bit configuration word. Software reaches each word through three access kinds: a plain write that replaces the word, a set alias that ORs in ones, and a clear alias that removes ones. The usual way to change a select is to clear its field through the clear alias and then set the new code through the set alias.

A new code written into a word is only pending. For almost every multiplexer, the code reaches the select output when software writes a one to that multiplexer's bit in a commit register. One multiplexer has no commit bit. Its output follows its field at once. The switching cells themselves sit outside this block and take the select outputs.

Top module: `clksel_bank`

## Requirements
- R1: After reset, every configuration word reads 0 and every select output is 0.
- R2: A write with access kind 0 (address bits [ADDR_W-1:ADDR_W-2] = 0, word index in the low IDX_W bits) replaces the word with the write data masked to its field bits. Bits outside any field read as 0.
- R3: Kind 1 is the set alias and sets the field bits where the data has ones. Kind 2 is the clear alias and clears the bits where the data has ones. Zero data bits leave the word unchanged under both aliases.
- R4: A write of kind 0, 1 or 2 never changes the select output of a multiplexer that has a commit bit.
- R5: A write of kind 3 to commit register r with bit b set copies the pending field of the mapped multiplexer to its select output. The output changes on the clock edge that takes the write.
- R6: A commit write moves only the multiplexers whose bits are 1. Every other select output keeps its value.
- R7: Commit bits are numbered in multiplexer order and skip the immediate multiplexer. Commit index k maps to register k/31, bit k%31. Bit 31 of every commit register is unused and has no effect.
- R8: The immediate multiplexer (default index 17) updates its select output on the same edge that its field is written, by any of the three access kinds.
- R9: Reads of kind 3 return 0. Accesses to a word index at or above NUM_WORDS, or to a commit register that does not exist, change nothing, and such reads return 0.
- R10: Multiplexer m sits in word m/4, at bit 8*(m%4), and is ((m + m/4) mod 4) + 1 bits wide. Its output is slot m of sel_o, 4 bits wide and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (7) | Access kind in the top two bits, word or commit-register index below |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data for addr, combinational |
| sel_o | output | NUM_MUX*4 (272) | Committed select codes, 4 bits per multiplexer |

## Verification
The bench checks that pending fields stay off the outputs while the aliases edit them. A design that forwarded writes directly would move sel_o too early. The bench writes bit 31 of a commit register and also hits the commit bits at the start of the second and third registers and the last bit used. An off-by-one in the mapping, or a design that did not skip the immediate multiplexer, would then commit the wrong multiplexer. The bench also exercises the immediate multiplexer through all three access kinds and writes data outside the field masks. Finally, it accesses out-of-range word and commit indices, where a design with loose decoding would alias onto a real word.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;

    localparam int LANES       = 4;
    localparam int LANE_STRIDE = 8;
    localparam int SLOT_W      = 4;
    localparam int WORD_W      = 32;

    typedef enum logic [1:0] {
        AK_PLAIN  = 2'd0,
        AK_SET    = 2'd1,
        AK_CLR    = 2'd2,
        AK_COMMIT = 2'd3
    } acc_kind_e;

    // Field width of multiplexer m, from 1 to SLOT_W bits
    function automatic int sel_width(input int m);
        return ((m + m / LANES) % LANES) + 1;
    endfunction

    // Bits of word w that belong to some field
    function automatic logic [WORD_W-1:0] word_mask(input int w);
        logic [WORD_W-1:0] mk;
        mk = '0;
        for (int l = 0; l < LANES; l++) begin
            for (int b = 0; b < sel_width(w * LANES + l); b++) begin
                mk[l * LANE_STRIDE + b] = 1'b1;
            end
        end
        return mk;
    endfunction

    // Commit index of multiplexer m, or -1 for the immediate one
    function automatic int commit_index(input int m, input int imm);
        if (m == imm) return -1;
        if (imm >= 0 && m > imm) return m - 1;
        return m;
    endfunction

endpackage

// File: rtl/clksel_decode.sv
`timescale 1ns/1ps
module clksel_decode
    import clksel_pkg::*;
#(
    parameter int NUM_WORDS    = 17,
    parameter int NUM_UPD_REGS = 3,
    parameter int IDX_W        = 5
) (
    input  logic [IDX_W+1:0]        addr,
    input  logic                    we,
    output logic [NUM_WORDS-1:0]    plain_we,
    output logic [NUM_WORDS-1:0]    set_we,
    output logic [NUM_WORDS-1:0]    clr_we,
    output logic [NUM_UPD_REGS-1:0] commit_we
);

    acc_kind_e        kind;
    logic [IDX_W-1:0] idx;

    always_comb begin
        kind      = acc_kind_e'(addr[IDX_W+1:IDX_W]);
        idx       = addr[IDX_W-1:0];
        plain_we  = '0;
        set_we    = '0;
        clr_we    = '0;
        commit_we = '0;
        for (int w = 0; w < NUM_WORDS; w++) begin
            if (we && idx == IDX_W'(w)) begin
                plain_we[w] = (kind == AK_PLAIN);
                set_we[w]   = (kind == AK_SET);
                clr_we[w]   = (kind == AK_CLR);
            end
        end
        for (int r = 0; r < NUM_UPD_REGS; r++) begin
            if (we && idx == IDX_W'(r)) begin
                commit_we[r] = (kind == AK_COMMIT);
            end
        end
    end

endmodule

// File: rtl/clksel_word.sv
`timescale 1ns/1ps
module clksel_word
    import clksel_pkg::*;
#(
    parameter logic [WORD_W-1:0] MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              plain_we,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] cfg_d,
    output logic [WORD_W-1:0] cfg_q
);

    typedef struct packed {
        logic [WORD_W-1:0] cfg;
    } word_st_t;

    word_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (plain_we) begin
            st_d.cfg = wdata & MASK;
        end else if (set_we) begin
            st_d.cfg = st_q.cfg | (wdata & MASK);
        end else if (clr_we) begin
            st_d.cfg = st_q.cfg & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_d = st_d.cfg;
    assign cfg_q = st_q.cfg;

endmodule

// File: rtl/clksel_commit.sv
`timescale 1ns/1ps
module clksel_commit #(
    parameter int WIDTH     = 1,
    parameter bit IMMEDIATE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             commit,
    input  logic [WIDTH-1:0] field_d,
    output logic [WIDTH-1:0] sel_q
);

    typedef struct packed {
        logic [WIDTH-1:0] sel;
    } sel_st_t;

    sel_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (IMMEDIATE) begin
            st_d.sel = field_d;
        end else if (commit) begin
            st_d.sel = field_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_q = st_q.sel;

endmodule

// File: rtl/clksel_bank.sv
`timescale 1ns/1ps
module clksel_bank
    import clksel_pkg::*;
#(
    parameter  int NUM_WORDS    = 17,
    parameter  int IMM_MUX      = 17,
    parameter  int COMMIT_BITS  = 31,
    localparam int NUM_MUX      = NUM_WORDS * LANES,
    localparam int NUM_UPD      = (IMM_MUX >= 0 && IMM_MUX < NUM_MUX) ? NUM_MUX - 1 : NUM_MUX,
    localparam int NUM_UPD_REGS = (NUM_UPD + COMMIT_BITS - 1) / COMMIT_BITS,
    localparam int IDX_SPAN     = (NUM_WORDS > NUM_UPD_REGS) ? NUM_WORDS : NUM_UPD_REGS,
    localparam int IDX_W        = (IDX_SPAN > 1) ? $clog2(IDX_SPAN) : 1,
    localparam int ADDR_W       = IDX_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [WORD_W-1:0]         wdata,
    input  logic                      we,
    output logic [WORD_W-1:0]         rdata,
    output logic [NUM_MUX*SLOT_W-1:0] sel_o
);

    logic [NUM_WORDS-1:0]        plain_we, set_we, clr_we;
    logic [NUM_UPD_REGS-1:0]     commit_we;
    logic [NUM_WORDS*WORD_W-1:0] cfg_flat;
    logic [NUM_WORDS*WORD_W-1:0] cfg_next;

    clksel_decode #(
        .NUM_WORDS   (NUM_WORDS),
        .NUM_UPD_REGS(NUM_UPD_REGS),
        .IDX_W       (IDX_W)
    ) u_dec (
        .addr     (addr),
        .we       (we),
        .plain_we (plain_we),
        .set_we   (set_we),
        .clr_we   (clr_we),
        .commit_we(commit_we)
    );

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        clksel_word #(
            .MASK(word_mask(w))
        ) u_word (
            .clk     (clk),
            .rst_n   (rst_n),
            .plain_we(plain_we[w]),
            .set_we  (set_we[w]),
            .clr_we  (clr_we[w]),
            .wdata   (wdata),
            .cfg_d   (cfg_next[w*WORD_W +: WORD_W]),
            .cfg_q   (cfg_flat[w*WORD_W +: WORD_W])
        );
    end

    for (genvar m = 0; m < NUM_MUX; m++) begin : g_mux
        localparam int  FW  = sel_width(m);
        localparam int  CI  = commit_index(m, IMM_MUX);
        localparam bit  IMM = (CI < 0);
        localparam int  RI  = IMM ? 0 : CI / COMMIT_BITS;
        localparam int  BI  = IMM ? 0 : CI % COMMIT_BITS;
        localparam int  LO  = (m / LANES) * WORD_W + (m % LANES) * LANE_STRIDE;

        logic          commit;
        logic [FW-1:0] sel;

        assign commit = commit_we[RI] & wdata[BI];

        clksel_commit #(
            .WIDTH    (FW),
            .IMMEDIATE(IMM)
        ) u_commit (
            .clk    (clk),
            .rst_n  (rst_n),
            .commit (commit),
            .field_d(cfg_next[LO +: FW]),
            .sel_q  (sel)
        );

        assign sel_o[m*SLOT_W +: SLOT_W] = SLOT_W'(sel);
    end

    always_comb begin
        rdata = '0;
        if (acc_kind_e'(addr[ADDR_W-1 -: 2]) != AK_COMMIT &&
            int'(addr[IDX_W-1:0]) < NUM_WORDS) begin
            rdata = cfg_flat[int'(addr[IDX_W-1:0]) * WORD_W +: WORD_W];
        end
    end

endmodule

// File: rtl/clksel_bank_chk.sv
`timescale 1ns/1ps
module clksel_bank_chk
    import clksel_pkg::*;
#(
    parameter int NUM_WORDS = 17,
    parameter int IMM_MUX   = 17,
    parameter int IDX_W     = 5,
    parameter int NUM_MUX   = 68
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [IDX_W+1:0]            addr,
    input logic [WORD_W-1:0]           wdata,
    input logic                        we,
    input logic [WORD_W-1:0]           rdata,
    input logic [NUM_MUX*SLOT_W-1:0]   sel_o,
    input logic [NUM_WORDS*WORD_W-1:0] cfg_flat
);

    function automatic logic [NUM_WORDS*WORD_W-1:0] all_masks();
        logic [NUM_WORDS*WORD_W-1:0] v;
        for (int w = 0; w < NUM_WORDS; w++) v[w*WORD_W +: WORD_W] = word_mask(w);
        return v;
    endfunction

    function automatic logic [NUM_MUX*SLOT_W-1:0] slot_ok();
        logic [NUM_MUX*SLOT_W-1:0] v;
        v = '0;
        for (int m = 0; m < NUM_MUX; m++)
            for (int b = 0; b < sel_width(m); b++) v[m*SLOT_W + b] = 1'b1;
        return v;
    endfunction

    function automatic logic [NUM_MUX*SLOT_W-1:0] imm_slot();
        logic [NUM_MUX*SLOT_W-1:0] v;
        v = '0;
        for (int m = 0; m < NUM_MUX; m++)
            if (m == IMM_MUX) v[m*SLOT_W +: SLOT_W] = '1;
        return v;
    endfunction

    localparam logic [NUM_WORDS*WORD_W-1:0] MASKS   = all_masks();
    localparam logic [NUM_MUX*SLOT_W-1:0]   PAD_OK  = slot_ok();
    localparam logic [NUM_MUX*SLOT_W-1:0]   IMM_BIT = imm_slot();

    logic [1:0] kind;
    int         widx;
    assign kind = addr[IDX_W+1:IDX_W];
    assign widx = int'(addr[IDX_W-1:0]);

    AST_PLAIN_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind == 2'd0 && widx < NUM_WORDS) |=>
        cfg_flat[$past(widx)*WORD_W +: WORD_W] ==
        ($past(wdata) & MASKS[$past(widx)*WORD_W +: WORD_W])); // R2

    AST_FIELD_WRITE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (we && kind != 2'd3) |=> ((sel_o & ~IMM_BIT) == $past(sel_o & ~IMM_BIT))); // R4

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(sel_o) && $stable(cfg_flat))); // R6

    AST_COMMIT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == 2'd3) |-> (rdata == '0)); // R9

    AST_SLOT_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((sel_o & ~PAD_OK) == '0)); // R10

    if (IMM_MUX >= 0 && IMM_MUX < NUM_MUX) begin : g_imm
        localparam int LO = (IMM_MUX / LANES) * WORD_W + (IMM_MUX % LANES) * LANE_STRIDE;
        localparam int FW = sel_width(IMM_MUX);
        AST_IMM_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            sel_o[IMM_MUX*SLOT_W +: SLOT_W] == SLOT_W'(cfg_flat[LO +: FW])); // R8
    end

endmodule

bind clksel_bank clksel_bank_chk #(
    .NUM_WORDS(NUM_WORDS),
    .IMM_MUX  (IMM_MUX),
    .IDX_W    (IDX_W),
    .NUM_MUX  (NUM_MUX)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wdata   (wdata),
    .we      (we),
    .rdata   (rdata),
    .sel_o   (sel_o),
    .cfg_flat(cfg_flat)
);

// File: tb/sim_clksel_bank.sv
`timescale 1ns/1ps
module sim_clksel_bank;

    localparam int NW  = 17;
    localparam int IMM = 17;
    localparam int CB  = 31;
    localparam int NM  = NW * 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [6:0]        addr = '0;
    logic [31:0]       wdata = '0;
    logic              we = 1'b0;
    logic [31:0]       rdata;
    logic [NM*4-1:0]   sel_o;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_cfg [NW];
    int exp_sel [NM];

    always #2.5 clk = ~clk;

    clksel_bank u0 (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (addr),
        .wdata(wdata),
        .we   (we),
        .rdata(rdata),
        .sel_o(sel_o)
    );

    // Model from R10 and R7
    function automatic int mwidth(input int m);
        return ((m + m / 4) % 4) + 1;
    endfunction

    function automatic logic [31:0] mmask(input int w);
        logic [31:0] k = '0;
        for (int l = 0; l < 4; l++)
            for (int b = 0; b < mwidth(w * 4 + l); b++) k[l*8 + b] = 1'b1;
        return k;
    endfunction

    function automatic int mfield(input int m);
        return (exp_cfg[m/4] >> (8 * (m % 4))) & ((1 << mwidth(m)) - 1);
    endfunction

    function automatic int mcidx(input int m);
        if (m == IMM) return -1;
        return (m > IMM) ? m - 1 : m;
    endfunction

    function automatic logic [NM*4-1:0] exp_flat();
        logic [NM*4-1:0] f;
        for (int m = 0; m < NM; m++) f[m*4 +: 4] = 4'(exp_sel[m]);
        return f;
    endfunction

    task automatic wr(input int kind, input int idx, input logic [31:0] d);
        @(negedge clk);
        addr  = {2'(kind), 5'(idx)};
        wdata = d;
        we    = 1'b1;
        @(negedge clk);
        we    = 1'b0;
        if (kind < 3 && idx < NW) begin
            if (kind == 0)      exp_cfg[idx] = int'(d & mmask(idx));
            else if (kind == 1) exp_cfg[idx] = exp_cfg[idx] | int'(d & mmask(idx));
            else                exp_cfg[idx] = exp_cfg[idx] & ~int'(d);
            exp_sel[IMM] = mfield(IMM);
        end else if (kind == 3) begin
            for (int m = 0; m < NM; m++) begin
                int c = mcidx(m);
                if (c >= 0 && c / CB == idx && d[c % CB]) exp_sel[m] = mfield(m);
            end
        end
    endtask

    task automatic rd(input int kind, input int idx, output logic [31:0] v);
        @(negedge clk);
        addr = {2'(kind), 5'(idx)};
        we   = 1'b0;
        #1;
        v = rdata;
    endtask

    task automatic cmp32(input string tag, input logic [31:0] act, input logic [31:0] ex);
        n_cmp++;
        if (act !== ex) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, ex);
        end
    endtask

    task automatic check_sel(input string tag);
        logic [NM*4-1:0] e;
        @(negedge clk);
        e = exp_flat();
        n_cmp++;
        if (sel_o !== e) begin
            n_bad++;
            $display("FAIL %s: sel_o actual %h expected %h", tag, sel_o, e);
        end
    endtask

    task automatic check_word(input string tag, input int w);
        logic [31:0] v;
        rd(0, w, v);
        cmp32(tag, v, exp_cfg[w]);
    endtask

    task automatic check_all_words(input string tag);
        for (int w = 0; w < NW; w++) check_word(tag, w);
    endtask

    task automatic t_reset();
        check_all_words("R1 word after reset");
        check_sel("R1 select after reset");
    endtask

    task automatic t_plain();
        wr(0, 0, 32'hFFFF_FFFF);
        check_word("R2 R10 plain all-ones masked", 0);
        cmp32("R10 word0 field layout", exp_cfg[0], 32'h0F07_0301);
        wr(0, 1, 32'hA5A5_A5A5);
        check_word("R2 plain pattern", 1);
        check_sel("R4 plain write pending only");
    endtask

    task automatic t_setclr();
        wr(2, 0, 32'h0000_FF00);
        check_word("R3 clear alias lane1", 0);
        wr(1, 0, 32'h0000_0100);
        check_word("R3 set alias lane1", 0);
        wr(1, 0, 32'hF0F0_F0F0);
        check_word("R3 set outside mask", 0);
        wr(2, 1, 32'h0000_0000);
        check_word("R3 clear with zeros", 1);
        check_sel("R4 alias writes pending only");
    endtask

    task automatic t_commit();
        wr(3, 0, 32'h0000_0001);
        check_sel("R5 commit mux0");
        cmp32("R5 mux0 slot", 32'(sel_o[3:0]), 32'h1);
        wr(0, 0, 32'h0000_0000);
        wr(3, 0, 32'h0000_0030);
        check_sel("R6 commit mux4 mux5 only");
    endtask

    task automatic t_numbering();
        wr(0, 4, 32'hFFFF_FFFF);
        check_sel("R8 immediate mux on plain write");
        wr(0, 8, 32'hFFFF_FFFF);
        wr(0, 15, 32'hFFFF_FFFF);
        wr(0, 16, 32'hFFFF_FFFF);
        wr(3, 0, 32'h8000_0000);
        check_sel("R7 bit31 unused");
        wr(3, 0, 32'h0002_0000);
        check_sel("R7 bit17 maps to mux18");
        wr(3, 1, 32'h0000_0001);
        check_sel("R7 second register bit0 maps to mux32");
        wr(3, 2, 32'h0000_0011);
        check_sel("R7 third register maps to mux63 and mux67");
    endtask

    task automatic t_immediate();
        wr(2, 4, 32'hFFFF_FFFF);
        check_sel("R8 immediate mux on clear alias");
        wr(1, 4, 32'h0000_0200);
        check_sel("R8 immediate mux on set alias");
        cmp32("R8 mux17 slot", 32'(sel_o[17*4 +: 4]), 32'h2);
    endtask

    task automatic t_misc();
        logic [31:0] v;
        rd(3, 0, v);
        cmp32("R9 commit register reads zero", v, 32'h0);
        rd(0, 20, v);
        cmp32("R9 out-of-range word reads zero", v, 32'h0);
        wr(0, 20, 32'hFFFF_FFFF);
        wr(1, 31, 32'hFFFF_FFFF);
        check_all_words("R9 out-of-range write ignored");
        wr(3, 5, 32'hFFFF_FFFF);
        check_sel("R9 missing commit register ignored");
    endtask

    initial begin
        for (int i = 0; i < NW; i++) exp_cfg[i] = 0;
        for (int i = 0; i < NM; i++) exp_sel[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_plain();
        t_setclr();
        t_commit();
        t_numbering();
        t_immediate();
        t_misc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule